// File: doc/BRIEF.md
# Video-Memory Contention Delay Generator

This block models the wait-state logic of a video controller that shares its RAM with the CPU. A beam-position counter advances once per CPU clock through the cycles of a scan line and the lines of a frame. From that position the block computes how many wait cycles a CPU bus cycle must be stretched when its address falls in the shared RAM window, and it raises a one-cycle frame interrupt at a fixed position before the first display fetch of each frame.

The CPU side presents one bus cycle at a time: a request strobe, the cycle kind (memory, I/O or internal), the address and, for internal cycles, their length in CPU cycles. The total delay for that bus cycle appears on the output in the following clock cycle. A two-bit selector picks one of three machine variants. They differ in line length, line count, the eight-cycle delay pattern, the contended width of a line and the interrupt lead. I/O and internal cycles are contended by address and by the low address bit only on the two older variants.

Top module: `vmc_contention`

## Requirements
- R1: Beam position runs hpos 0..L-1 and line 0..N-1, with L=224, N=312 for variant 0 and L=228, N=311 for variants 2 and 1; after the last cycle of the last line both return to 0. Variant code 3 behaves as variant 2.
- R2: On variants 0 and 1, a memory cycle to an address in 0x4000..0x7FFF, presented at beam position (line, hpos) inside the contended window, gets delay 6,5,4,3,2,1,0,0 for hpos mod 8 = 0..7.
- R3: On variant 2 the same memory cycle gets delay 1,0,7,6,5,4,3,2 for hpos mod 8 = 0..7.
- R4: The contended window is lines 0..191 with hpos below 128 (variants 0 and 1) or below 129 (variant 2); outside it, or for an address outside 0x4000..0x7FFF, a check yields 0.
- R5: On variants 0 and 1, an I/O cycle (kind 1) with address in 0x4000..0x7FFF is checked 4 times when A0=1 and 2 times when A0=0; the first check is at the request position, each later one at the previous position plus its delay plus 1; the output is the sum.
- R6: On variants 0 and 1, an I/O cycle outside that range with A0=0 is checked once at the request position plus 1; with A0=1 its delay is 0.
- R7: On variants 0 and 1, an internal cycle (kind 2) of length n (clamped to 8) on a contended address is checked n times, chained as in R5; on variant 2, I/O and internal cycles always give delay 0.
- R8: The interrupt output is high for exactly the one cycle at frame position L*N minus 14339 (variant 0), 14366 (variant 1) or 14368 (variant 2), counted from line 0, hpos 0.
- R9: The delay output shows the result in the cycle after the request cycle (kind 0 is memory) and is 0 in any cycle that follows a cycle without a request.
- R10: During and right after reset the beam sits at line 0, hpos 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_i | input | 2 | Machine variant: 0, 1, 2 (3 acts as 2) |
| req_i | input | 1 | A bus cycle starts in this clock cycle |
| kind_i | input | 2 | Cycle kind: 0 memory, 1 I/O, 2 internal |
| addr_i | input | 16 | Address or port address of the cycle |
| len_i | input | 4 | Length of an internal cycle in CPU cycles |
| delay_o | output | 6 | Total wait cycles for the previous cycle's request |
| irq_o | output | 1 | One-cycle frame interrupt strobe |

## Verification
A multi-check I/O or internal cycle can run across the right edge of the contended window, so a single request mixes checks from the fetch pattern with checks that fall in the idle part of the line. The bench places four-check I/O cycles a few cycles before hpos 128 on the last active line and next to line 192, and judges the summed delay against the value worked out from linear frame positions. It also places requests at hpos 128 and 129 on the latest variant to see the one-cycle difference in window width. The interrupt is sampled one cycle before, at and one cycle after its position to confirm a single-cycle strobe.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  localparam int H_W = 8;
  localparam int L_W = 9;
  localparam logic [L_W-1:0] ACTIVE_LINES = 9'd192;
  localparam logic [15:0] CONT_LO = 16'h4000;
  localparam logic [15:0] CONT_HI = 16'h7FFF;

  localparam logic [1:0] KIND_MEM = 2'd0;
  localparam logic [1:0] KIND_IO  = 2'd1;
  localparam logic [1:0] KIND_INT = 2'd2;

  typedef struct packed {
    logic [L_W-1:0] line;
    logic [H_W-1:0] h;
  } pos_t;

  function automatic logic [H_W-1:0] line_len(input logic [1:0] v);
    return (v == 2'd0) ? 8'd224 : 8'd228;
  endfunction

  function automatic logic [L_W-1:0] frame_lines(input logic [1:0] v);
    return (v == 2'd0) ? 9'd312 : 9'd311;
  endfunction

  function automatic logic [H_W-1:0] window_len(input logic [1:0] v);
    return v[1] ? 8'd129 : 8'd128;
  endfunction

  // Delay inside the eight-cycle fetch group
  function automatic logic [2:0] pattern_delay(input logic [1:0] v, input logic [2:0] idx);
    if (!v[1]) return (idx < 3'd6) ? 3'(3'd6 - idx) : 3'd0;
    if (idx == 3'd0) return 3'd1;
    if (idx == 3'd1) return 3'd0;
    return 3'(4'd9 - {1'b0, idx});
  endfunction

  // Interrupt position, expressed as line and cycle-in-line
  function automatic pos_t irq_pos(input logic [1:0] v);
    int t;
    int cpl;
    pos_t r;
    case (v)
      2'd0:    begin cpl = 224; t = 224 * 312 - 14339; end
      2'd1:    begin cpl = 228; t = 228 * 311 - 14366; end
      default: begin cpl = 228; t = 228 * 311 - 14368; end
    endcase
    r.line = L_W'(t / cpl);
    r.h    = H_W'(t % cpl);
    return r;
  endfunction

  // Move a beam position forward by k cycles (k well below a line)
  function automatic pos_t pos_advance(input logic [1:0] v, input pos_t p, input logic [3:0] k);
    pos_t r;
    logic [H_W:0] s;
    logic [H_W:0] len;
    len = {1'b0, line_len(v)};
    s = {1'b0, p.h} + (H_W+1)'(k);
    if (s >= len) begin
      r.h = H_W'(s - len);
      r.line = (p.line >= frame_lines(v) - 1'b1) ? '0 : p.line + 1'b1;
    end else begin
      r.h = s[H_W-1:0];
      r.line = p.line;
    end
    return r;
  endfunction
endpackage

// File: rtl/vmc_beam.sv
module vmc_beam
  import vmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] variant_i,
  output pos_t       pos_o,
  output logic       irq_o
);
  pos_t pos_q;
  pos_t irq_at;
  logic last_h;
  logic last_line;

  assign last_h    = (pos_q.h >= line_len(variant_i) - 1'b1);
  assign last_line = (pos_q.line >= frame_lines(variant_i) - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (last_h) begin
      pos_q.h <= '0;
      pos_q.line <= last_line ? '0 : pos_q.line + 1'b1;
    end else begin
      pos_q.h <= pos_q.h + 1'b1;
    end
  end

  assign irq_at = irq_pos(variant_i);
  assign irq_o  = rst_n && (pos_q == irq_at);
  assign pos_o  = pos_q;
endmodule

// File: rtl/vmc_slot.sv
module vmc_slot
  import vmc_pkg::*;
(
  input  logic [1:0] variant_i,
  input  logic       en_i,
  input  pos_t       at_i,
  output logic [2:0] delay_o,
  output pos_t       next_o
);
  logic hot;
  assign hot = en_i && (at_i.line < ACTIVE_LINES) && (at_i.h < window_len(variant_i));
  assign delay_o = hot ? pattern_delay(variant_i, at_i.h[2:0]) : 3'd0;
  assign next_o  = pos_advance(variant_i, at_i, {1'b0, delay_o} + 4'd1);
endmodule

// File: rtl/vmc_contention.sv
module vmc_contention
  import vmc_pkg::*;
#(
  parameter int MAX_CHECKS = 8,
  parameter int LEN_W = 4,
  localparam int N_W = $clog2(MAX_CHECKS + 1),
  localparam int DLY_W = $clog2(MAX_CHECKS * 7 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       variant_i,
  input  logic             req_i,
  input  logic [1:0]       kind_i,
  input  logic [15:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DLY_W-1:0] delay_o,
  output logic             irq_o
);
  pos_t beam_pos;
  pos_t start_pos;
  logic in_range;
  logic late;
  logic [N_W-1:0] n_checks;
  logic [DLY_W-1:0] total;
  pos_t chain [MAX_CHECKS+1];
  logic [2:0] slot_dly [MAX_CHECKS];

  vmc_beam beam_i (
    .clk(clk), .rst_n(rst_n), .variant_i(variant_i),
    .pos_o(beam_pos), .irq_o(irq_o)
  );

  assign in_range = (addr_i >= CONT_LO) && (addr_i <= CONT_HI);
  assign late = variant_i[1];

  // Number of checks and where the first one lands
  always_comb begin
    n_checks = '0;
    start_pos = beam_pos;
    case (kind_i)
      KIND_MEM: n_checks = in_range ? N_W'(1) : '0;
      KIND_IO: if (!late) begin
        if (in_range) n_checks = addr_i[0] ? N_W'(4) : N_W'(2);
        else if (!addr_i[0]) begin
          n_checks = N_W'(1);
          start_pos = pos_advance(variant_i, beam_pos, 4'd1);
        end
      end
      KIND_INT: if (!late && in_range) begin
        if (int'(len_i) > MAX_CHECKS) n_checks = N_W'(MAX_CHECKS);
        else n_checks = N_W'(len_i);
      end
      default: n_checks = '0;
    endcase
  end

  assign chain[0] = start_pos;

  for (genvar i = 0; i < MAX_CHECKS; i++) begin : g_slot
    vmc_slot slot_i (
      .variant_i(variant_i),
      .en_i(N_W'(i) < n_checks),
      .at_i(chain[i]),
      .delay_o(slot_dly[i]),
      .next_o(chain[i+1])
    );
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < MAX_CHECKS; i++) total = total + DLY_W'(slot_dly[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) delay_o <= '0;
    else delay_o <= req_i ? total : '0;
  end
endmodule

// File: rtl/vmc_contention_chk.sv
module vmc_contention_chk
  import vmc_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       variant_i,
  input logic             req_i,
  input logic [1:0]       kind_i,
  input logic [15:0]      addr_i,
  input logic [DLY_W-1:0] delay_o,
  input logic             irq_o,
  input pos_t             beam
);
  AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (beam.h < line_len(variant_i)) && (beam.line < frame_lines(variant_i))); // R1

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beam.h == line_len(variant_i) - 1'b1 && beam.line == frame_lines(variant_i) - 1'b1)
    |=> (beam.h == '0 && beam.line == '0)); // R1

  AST_MEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && kind_i == KIND_MEM) |=> (delay_o <= DLY_W'(7))); // R2

  AST_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && kind_i == KIND_MEM && beam.line >= ACTIVE_LINES) |=> (delay_o == '0)); // R4

  AST_UNCONTENDED_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && kind_i == KIND_MEM && (addr_i < CONT_LO || addr_i > CONT_HI)) |=> (delay_o == '0)); // R4

  AST_LATE_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && variant_i[1] && kind_i != KIND_MEM) |=> (delay_o == '0)); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (delay_o == '0)); // R9
endmodule

bind vmc_contention vmc_contention_chk #(.DLY_W(DLY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .variant_i(variant_i), .req_i(req_i),
  .kind_i(kind_i), .addr_i(addr_i), .delay_o(delay_o), .irq_o(irq_o),
  .beam(beam_pos)
);

// File: tb/vmc_contention_tb.sv
module vmc_contention_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant_i = 2'd0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [15:0] addr_i = 16'h0000;
  logic [3:0]  len_i = 4'd0;
  logic [5:0]  delay_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  int edges = 0;

  always #5 clk = ~clk;

  vmc_contention dut_i (
    .clk(clk), .rst_n(rst_n), .variant_i(variant_i), .req_i(req_i),
    .kind_i(kind_i), .addr_i(addr_i), .len_i(len_i),
    .delay_o(delay_o), .irq_o(irq_o)
  );

  // Bench timebase: cycles since reset release
  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else edges <= edges + 1;
  end

  typedef struct packed {
    logic [1:0]  v;
    logic [16:0] p;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [3:0]  len;
    logic [5:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 17'd10,    2'd0, 16'h4000, 4'd0, 6'd4,  4'd2},  // R2 idx2
    '{2'd0, 17'd20,    2'd0, 16'h8000, 4'd0, 6'd0,  4'd4},  // R4 address outside
    '{2'd0, 17'd30,    2'd0, 16'h5555, 4'd0, 6'd0,  4'd2},  // R2 idx6
    '{2'd0, 17'd40,    2'd1, 16'h4001, 4'd0, 6'd12, 4'd5},  // R5 four checks
    '{2'd0, 17'd60,    2'd1, 16'h40FE, 4'd0, 6'd2,  4'd5},  // R5 two checks
    '{2'd0, 17'd80,    2'd1, 16'h00FE, 4'd0, 6'd5,  4'd6},  // R6 one later
    '{2'd0, 17'd90,    2'd1, 16'h00FF, 4'd0, 6'd0,  4'd6},  // R6 odd port
    '{2'd0, 17'd100,   2'd2, 16'h4000, 4'd3, 6'd8,  4'd7},  // R7 internal x3
    '{2'd0, 17'd125,   2'd0, 16'h7FFF, 4'd0, 6'd1,  4'd2},  // R2 idx5
    '{2'd0, 17'd128,   2'd0, 16'h4000, 4'd0, 6'd0,  4'd4},  // R4 hpos 128
    '{2'd0, 17'd224,   2'd0, 16'h4000, 4'd0, 6'd6,  4'd1},  // R1 line 1 at 224
    '{2'd0, 17'd250,   2'd2, 16'h4000, 4'd2, 6'd4,  4'd7},  // R7 internal x2
    '{2'd0, 17'd42784, 2'd0, 16'h4000, 4'd0, 6'd6,  4'd4},  // R4 line 191
    '{2'd0, 17'd42908, 2'd1, 16'h7FFF, 4'd0, 6'd2,  4'd5},  // R5 across window edge
    '{2'd0, 17'd43008, 2'd0, 16'h4000, 4'd0, 6'd0,  4'd4},  // R4 line 192
    '{2'd2, 17'd8,     2'd0, 16'h4000, 4'd0, 6'd1,  4'd3},  // R3 idx0
    '{2'd2, 17'd10,    2'd0, 16'h4000, 4'd0, 6'd7,  4'd3},  // R3 idx2
    '{2'd2, 17'd40,    2'd1, 16'h4001, 4'd0, 6'd0,  4'd7},  // R7 late I/O
    '{2'd2, 17'd50,    2'd2, 16'h4000, 4'd4, 6'd0,  4'd7},  // R7 late internal
    '{2'd2, 17'd128,   2'd0, 16'h4000, 4'd0, 6'd1,  4'd4},  // R4 hpos 128 late
    '{2'd2, 17'd228,   2'd0, 16'h4000, 4'd0, 6'd1,  4'd1},  // R1 line 1 at 228
    '{2'd2, 17'd357,   2'd0, 16'h4000, 4'd0, 6'd0,  4'd4},  // R4 hpos 129 late
    '{2'd1, 17'd20,    2'd1, 16'h00FE, 4'd0, 6'd1,  4'd6},  // R6 mid
    '{2'd1, 17'd128,   2'd0, 16'h4000, 4'd0, 6'd0,  4'd4},  // R4 mid hpos 128
    '{2'd1, 17'd231,   2'd0, 16'h4000, 4'd0, 6'd3,  4'd2}   // R2 mid line 1
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, edges);
    end
  endtask

  task automatic wait_to(input int p);
    while (edges != p) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] v);
    @(negedge clk);
    rst_n = 1'b0;
    variant_i = v;
    req_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 delay in reset", int'(delay_o), 0);
    check("R10 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    check("R10 delay after reset", int'(delay_o), 0);
  endtask

  initial begin
    logic [1:0] gv [3];
    int irq_at [3];
    gv[0] = 2'd0; gv[1] = 2'd2; gv[2] = 2'd1;
    irq_at[0] = 224 * 312 - 14339;  // R8 variant 0
    irq_at[1] = 228 * 311 - 14368;  // R8 variant 2
    irq_at[2] = 228 * 311 - 14366;  // R8 variant 1
    for (int g = 0; g < 3; g++) begin
      do_reset(gv[g]);
      for (int i = 0; i < NV; i++) begin
        if (VEC[i].v == gv[g]) begin
          wait_to(int'(VEC[i].p));
          req_i = 1'b1;
          kind_i = VEC[i].kind;
          addr_i = VEC[i].addr;
          len_i = VEC[i].len;
          @(negedge clk);
          req_i = 1'b0;
          check($sformatf("R%0d vec %0d", VEC[i].req, i), int'(delay_o), int'(VEC[i].exp));
        end
      end
      // R9: contended address held but no request
      addr_i = 16'h4000;
      kind_i = 2'd0;
      @(negedge clk);
      check("R9 idle after request", int'(delay_o), 0);
      wait_to(irq_at[g] - 1);
      check("R8 irq before", int'(irq_o), 0);
      @(negedge clk);
      check("R8 irq at position", int'(irq_o), 1);
      @(negedge clk);
      check("R8 irq after", int'(irq_o), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule